// File: doc/BRIEF.md
# Sequential Flash Page Reader

This block sits between a processor bus and a banked word-organised flash store that software reads as a stream. Software selects a page by writing three times to a single data port. The first write of each group is a command slot and leaves the address alone. The second write takes the low page byte from bits 23:16 of the bus. The third write merges bits 23:16 into the high page byte and rewinds the word offset.

After that, every read of the same port fetches the next 16-bit word of the page. The word comes back zero-extended on the 32-bit bus. The offset steps by one after each fetch.

A separate I/O lines register supplies a bank bit, which moves the access into the upper half of the store. A write to that register with either of its two top bits set returns the write phase to the command slot, so software can resynchronise. A read whose address falls beyond the store fetches nothing and returns zero.

Top module: `flash_page_reader`

## Requirements
- R1: Data-port writes step a phase through command, low, high and back to command. A command-phase write changes no page, offset or bank state, whatever it carries.
- R2: A low-phase write sets the page to bits 23:16 of the write data and clears the page's upper byte.
- R3: A high-phase write ORs bits 23:16 of the write data into page bits 15:8 and sets the word offset to 0.
- R4: A lines write with bit 7 or bit 6 set puts the phase back to command. A lines write with both of those bits clear leaves the phase unchanged.
- R5: A read accesses word address page*512 + offset (plus the bank term), and an in-range read adds one to the offset.
- R6: The bank bit is lines bit 0, stored on every lines write; when it is 1, 4,194,304 is added to the word address.
- R7: When the word address is 8,388,608 or more, a read raises no storage access, returns 0 and leaves the offset unchanged.
- R8: `portRdValid` is high exactly in the cycle after a read request, with `portRdData` holding the 16-bit storage word in bits 15:0 and zeros in bits 31:16.
- R9: After reset the phase is command, the page, offset and bank are 0, and no read is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWr | input | 1 | Write strobe for the data port |
| portWrData | input | 32 | Data-port write data; bits 23:16 carry the page byte |
| portRd | input | 1 | Read strobe for the data port |
| portRdData | output | 32 | Zero-extended word, valid with portRdValid |
| portRdValid | output | 1 | Read data valid, one cycle after portRd |
| linesWr | input | 1 | Write strobe for the I/O lines register |
| linesWrData | input | 8 | Lines value: bit 0 bank, bits 7 and 6 phase clear |
| memRdEn | output | 1 | Storage read enable |
| memAddr | output | 23 | Storage word address |
| memRdData | input | 16 | Storage word, returned the cycle after memRdEn |

## Verification
The assertions assume that software never strobes a data-port read and a data-port write in the same cycle. They also assume that the storage returns its word exactly one cycle after the enable. The stimulus issues at most one operation per cycle and models the storage as a registered function of the address, so both assumptions hold. Random phases of writes, lines writes with and without the clear bits, and long read bursts across the top of the store are mixed within those limits.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic loadLow;   // low-phase write: set page low byte
    logic orHigh;    // high-phase write: merge page high byte, rewind offset
    logic bankLoad;  // lines write: capture bank bit
    logic rdReq;     // data-port read request
  } fpr_strb_t;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } fpr_phase_e;

endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
#(
  parameter int LINES_W = 8,
  parameter logic [LINES_W-1:0] CLR_MASK = 8'hC0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portWr,
  input  logic               portRd,
  input  logic               linesWr,
  input  logic [LINES_W-1:0] linesWrData,
  output fpr_strb_t          strb,
  output logic               rdValid
);

  fpr_phase_e phase;
  logic       phaseClr;

  assign phaseClr = linesWr && (|(linesWrData & CLR_MASK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      rdValid <= 1'b0;
    end else begin
      rdValid <= portRd;
      if (phaseClr) begin
        phase <= PH_CMD;
      end else if (portWr) begin
        unique case (phase)
          PH_CMD:  phase <= PH_LOW;
          PH_LOW:  phase <= PH_HIGH;
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  always_comb begin
    strb.loadLow  = portWr && (phase == PH_LOW);
    strb.orHigh   = portWr && (phase == PH_HIGH);
    strb.bankLoad = linesWr;
    strb.rdReq    = portRd;
  end

  // R1: command slot is always followed by the low slot
  a_r1_cmd_to_low: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && !phaseClr && phase == PH_CMD) |=> (phase == PH_LOW));

  // R1: high slot wraps to the command slot
  a_r1_high_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && !phaseClr && phase == PH_HIGH) |=> (phase == PH_CMD));

  // R4: clear bits force the command slot
  a_r4_phase_clear: assert property (@(posedge clk) disable iff (!rstN)
    phaseClr |=> (phase == PH_CMD));

  // R4: a lines write without clear bits and no data write keeps the phase
  a_r4_phase_keep: assert property (@(posedge clk) disable iff (!rstN)
    (linesWr && !phaseClr && !portWr) |=> $stable(phase));

  // R8: valid strobe follows a read by one cycle
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    portRd |=> rdValid);

  a_r8_valid_only_after_rd: assert property (@(posedge clk) disable iff (!rstN)
    !portRd |=> !rdValid);

  // R8: input assumption, reads and writes of the port never collide
  a_r8_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(portRd && portWr));

endmodule

// File: rtl/fpr_datapath.sv
module fpr_datapath
  import fpr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int OFS_W      = 16,
  parameter int PAGE_SHIFT = 9,
  parameter int BANK_LOG2  = 22,
  parameter int LIMIT_LOG2 = 23,
  parameter int WORD_W     = 16,
  parameter int BUS_W      = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fpr_strb_t             strb,
  input  logic [BYTE_W-1:0]     pageByte,
  input  logic                  bankBit,
  input  logic [WORD_W-1:0]     memRdData,
  output logic                  memRdEn,
  output logic [LIMIT_LOG2-1:0] memAddr,
  output logic [BUS_W-1:0]      rdData
);

  localparam int PAGE_W = 2 * BYTE_W;
  localparam int FULL_W = PAGE_W + PAGE_SHIFT + 2;
  localparam logic [FULL_W-1:0] LIMIT    = FULL_W'(1) << LIMIT_LOG2;
  localparam logic [FULL_W-1:0] BANK_ADD = FULL_W'(1) << BANK_LOG2;

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  offset;
  logic              bank;
  logic              hitQ;
  logic [FULL_W-1:0] fullAddr;
  logic              inRange;
  logic              hit;

  always_comb begin
    fullAddr = FULL_W'({page, {PAGE_SHIFT{1'b0}}}) + FULL_W'(offset)
             + (bank ? BANK_ADD : '0);
    inRange  = fullAddr < LIMIT;
    hit      = strb.rdReq && inRange;
  end

  assign memRdEn = hit;
  assign memAddr = fullAddr[LIMIT_LOG2-1:0];
  assign rdData  = hitQ ? BUS_W'(memRdData) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page   <= '0;
      offset <= '0;
      bank   <= 1'b0;
      hitQ   <= 1'b0;
    end else begin
      hitQ <= hit;
      if (strb.loadLow) page <= PAGE_W'(pageByte);
      else if (strb.orHigh) page <= page | (PAGE_W'(pageByte) << BYTE_W);
      if (strb.orHigh) offset <= '0;
      else if (hit) offset <= offset + 1'b1;
      if (strb.bankLoad) bank <= bankBit;
    end
  end

  // R2: a low-phase load leaves the upper page byte clear
  a_r2_high_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> (page[PAGE_W-1:BYTE_W] == '0));

  // R3: high-phase write rewinds the offset
  a_r3_offset_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strb.orHigh |=> (offset == '0));

  // R5: each storage access steps the offset by one
  a_r5_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !strb.orHigh) |=> (offset == OFS_W'($past(offset) + 1'b1)));

  // R7: an out-of-range read freezes the offset
  a_r7_offset_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && !memRdEn && !strb.orHigh) |=> $stable(offset));

  // R7: a read without storage access yields zero data
  a_r7_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && !memRdEn) |=> (rdData == '0));

endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import fpr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int BYTE_LSB   = 16,
  parameter int OFS_W      = 16,
  parameter int PAGE_SHIFT = 9,
  parameter int BANK_LOG2  = 22,
  parameter int LIMIT_LOG2 = 23,
  parameter int WORD_W     = 16,
  parameter int BUS_W      = 32,
  parameter int LINES_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  portWr,
  input  logic [BUS_W-1:0]      portWrData,
  input  logic                  portRd,
  output logic [BUS_W-1:0]      portRdData,
  output logic                  portRdValid,
  input  logic                  linesWr,
  input  logic [LINES_W-1:0]    linesWrData,
  output logic                  memRdEn,
  output logic [LIMIT_LOG2-1:0] memAddr,
  input  logic [WORD_W-1:0]     memRdData
);

  localparam logic [LINES_W-1:0] CLR_MASK = LINES_W'(8'hC0);

  fpr_strb_t         strb;
  logic [BYTE_W-1:0] pageByte;

  assign pageByte = BYTE_W'(portWrData >> BYTE_LSB);

  fpr_ctrl #(
    .LINES_W  (LINES_W),
    .CLR_MASK (CLR_MASK)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .portWr      (portWr),
    .portRd      (portRd),
    .linesWr     (linesWr),
    .linesWrData (linesWrData),
    .strb        (strb),
    .rdValid     (portRdValid)
  );

  fpr_datapath #(
    .BYTE_W     (BYTE_W),
    .OFS_W      (OFS_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BANK_LOG2  (BANK_LOG2),
    .LIMIT_LOG2 (LIMIT_LOG2),
    .WORD_W     (WORD_W),
    .BUS_W      (BUS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pageByte  (pageByte),
    .bankBit   (linesWrData[0]),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .rdData    (portRdData)
  );

endmodule

// File: tb/test_flash_page_reader.sv
`timescale 1ns/1ps
module test_flash_page_reader;

  localparam int LIMIT = 8388608;
  localparam int BANKW = 4194304;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portWr = 1'b0;
  logic [31:0] portWrData = '0;
  logic        portRd = 1'b0;
  logic [31:0] portRdData;
  logic        portRdValid;
  logic        linesWr = 1'b0;
  logic [7:0]  linesWrData = '0;
  logic        memRdEn;
  logic [22:0] memAddr;
  logic [15:0] memQ = '0;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;
  string curReq = "R9";

  always #2 clk = ~clk;

  flash_page_reader i_flash_page_reader (
    .clk (clk), .rstN (rstN),
    .portWr (portWr), .portWrData (portWrData),
    .portRd (portRd), .portRdData (portRdData), .portRdValid (portRdValid),
    .linesWr (linesWr), .linesWrData (linesWrData),
    .memRdEn (memRdEn), .memAddr (memAddr), .memRdData (memQ)
  );

  function automatic logic [15:0] wordAt(int a);
    return 16'((a ^ (a >> 7)) + 16'h1357);
  endfunction

  // behavioural storage: one cycle of latency
  always @(posedge clk) if (memRdEn) memQ <= wordAt(int'(memAddr));

  // reference model state
  int mPhase = 0, mPage = 0, mOfs = 0, mBank = 0;
  bit mValid = 1'b0;
  logic [31:0] mData = '0;
  string mTag = "R9";

  function automatic int addrNow();
    return mPage * 512 + mOfs + mBank * BANKW;
  endfunction

  always @(posedge clk) begin
    int a, b;
    if (!rstN) begin
      mPhase = 0; mPage = 0; mOfs = 0; mBank = 0; mValid = 1'b0;
    end else begin
      mValid = portRd;
      if (portRd) begin
        a = addrNow();
        if (a < LIMIT) begin
          mData = {16'h0, wordAt(a)}; mOfs = (mOfs + 1) % 65536; mTag = curReq;
        end else begin
          mData = '0; mTag = "R7";
        end
      end
      if (portWr) begin
        b = int'(portWrData[23:16]);
        if (mPhase == 1) mPage = b;
        else if (mPhase == 2) begin mPage = mPage | (b << 8); mOfs = 0; end
        mPhase = (mPhase + 1) % 3;
      end
      if (linesWr) begin
        mBank = int'(linesWrData[0]);
        if (linesWrData[7] || linesWrData[6]) mPhase = 0;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int a2;
    if (!done) begin
      if (!rstN) begin
        chk(portRdValid == 1'b0, "R9", 32'(portRdValid), 32'h0);
        chk(memRdEn == 1'b0, "R9", 32'(memRdEn), 32'h0);
      end else begin
        chk(portRdValid == mValid, "R8", 32'(portRdValid), 32'(mValid));
        if (mValid) chk(portRdData == mData, mTag, portRdData, mData);
        if (portRd) begin
          a2 = addrNow();
          chk(memRdEn == (a2 < LIMIT), "R7", 32'(memRdEn), 32'(a2 < LIMIT));
          if (a2 < LIMIT)
            chk(int'(memAddr) == a2, (mBank != 0) ? "R6" : curReq, 32'(memAddr), 32'(a2));
        end else begin
          chk(memRdEn == 1'b0, "R7", 32'(memRdEn), 32'h0);
        end
      end
    end
  end

  task automatic drive(bit w, bit r, bit l, logic [31:0] d, logic [7:0] ld);
    @(posedge clk); #1;
    portWr = w; portRd = r; linesWr = l; portWrData = d; linesWrData = ld;
  endtask
  task automatic wrB(logic [7:0] b); drive(1'b1, 1'b0, 1'b0, {8'h5A, b, 16'hC3C3}, 8'h0); endtask
  task automatic rd(); drive(1'b0, 1'b1, 1'b0, 32'h0, 8'h0); endtask
  task automatic idle(); drive(1'b0, 1'b0, 1'b0, 32'h0, 8'h0); endtask
  task automatic lines(logic [7:0] v); drive(1'b0, 1'b0, 1'b1, 32'h0, v); endtask
  task automatic setPage(logic [7:0] lo, logic [7:0] hi);
    wrB(8'hEE); wrB(lo); wrB(hi);   // R1: first write is a command slot
  endtask
  task automatic rdN(int n);
    for (int i = 0; i < n; i++) rd();
  endtask

  initial begin
    int seed, k;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R9"; rdN(2);             // page 0 offset 0 after reset
    curReq = "R1"; setPage(8'h03, 8'h00); rdN(4); idle();
    curReq = "R2"; setPage(8'hAB, 8'h12); rdN(3);
    setPage(8'h05, 8'h00); rdN(2);     // upper byte cleared by the low write
    curReq = "R3"; setPage(8'h05, 8'h00); rdN(3); idle();
    curReq = "R4";
    wrB(8'hEE); wrB(8'h55); lines(8'h80);
    setPage(8'h07, 8'h00); rdN(2);
    wrB(8'hEE); lines(8'h40); setPage(8'h08, 8'h00); rdN(2);
    wrB(8'hEE); lines(8'h02); wrB(8'h09); wrB(8'h00); rdN(2);
    curReq = "R6"; lines(8'h01); setPage(8'h10, 8'h00); rdN(3);
    curReq = "R7"; lines(8'h00); setPage(8'h00, 8'h40); rdN(3);
    setPage(8'hFF, 8'h3F); rdN(3);
    lines(8'h01); setPage(8'hFF, 8'h1F); rdN(515); idle();
    curReq = "R5"; lines(8'h00);
    seed = 7;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      k = (seed >>> 16) & 15;
      if (k < 8) rd();
      else if (k < 12) wrB(8'((seed >>> 4) & 8'h3F));
      else if (k < 14) lines(8'((seed >>> 8) & 8'hC3));
      else idle();
    end
    idle(); idle(); idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nErr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule